// File: doc/BRIEF.md
# ADC Routine Conversion Controller

This block is the digital sequencer in front of an analog-to-digital converter. It converts one selected channel, either once per trigger or repeatedly without further triggers. Each conversion has a sample phase, whose length comes from a per-channel table, followed by a convert phase. The convert phase is handed to an external converter through a start pulse. The converter answers with a done strobe and a 12-bit result.

Software sets the block up through a small write port with four addresses:

- **Address 0 (control):** bit 0 enable, bit 1 continuous, bit 2 external-trigger enable, bits 4:3 external source select, bit 5 DMA enable, bit 6 software start.
- **Address 1 (channel):** bits 4:0 give the channel number.
- **Address 2 (sample time):** bits 4:0 give the table index and bits 7:5 give the sample-time code.
- **Address 3 (status):** bit 0 is the end-of-conversion flag.

Each result is latched into a data register and sets the end-of-conversion flag. When DMA is enabled, each result also produces a one-cycle request.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With continuous clear, one trigger produces exactly one sample phase and one `adc_start` pulse, after which `adc_sample` stays low and the block is idle.
- R2: With continuous set, one trigger produces repeated conversions of the channel with no further trigger.
- R3: The channel number written at address 1 is presented on `adc_chan` for the whole conversion.
- R4: A conversion begins only while enable is 1. A software start written while enable is 0 stays pending on `sw_start` and begins the conversion once enable is set.
- R5: An external trigger starts a conversion only when the external-trigger enable is 1. It must be a rising edge on the `ext_trig` bit picked by the source select; edges on other bits do nothing.
- R6: The sample phase (`adc_sample` high) lasts 2*code+2 cycles, where code is the table entry for the converted channel. It is followed directly by a one-cycle `adc_start`.
- R7: On `adc_done` during the convert phase, `adc_data` is latched into `dout` and `eoc` is set in the same edge. `dout` changes at no other time, and reset clears `dout`, `eoc`, `dma_req`, `sw_start` and `adc_sample`.
- R8: Writing status with bit 0 = 0 clears `eoc`, and writing bit 0 = 1 leaves it unchanged. When a clear and a new result meet, the result wins.
- R9: With DMA enabled, each result gives exactly one one-cycle `dma_req` pulse, coincident with `eoc`. With DMA disabled, `dma_req` stays low.
- R10: The software start bit clears itself in the cycle the conversion begins.
- R11: Clearing continuous or enable during repeated conversion stops it after the conversion in progress completes.
- R12: Triggers arriving while a conversion is in progress are ignored: external edges are dropped, and a software start write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| ext_trig | input | 4 | External trigger sources |
| adc_done | input | 1 | Converter result strobe |
| adc_data | input | 12 | Converter result |
| adc_sample | output | 1 | Sample phase active |
| adc_start | output | 1 | One-cycle convert start |
| adc_chan | output | 5 | Channel being converted |
| dout | output | 12 | Latched result register |
| eoc | output | 1 | End-of-conversion flag |
| dma_req | output | 1 | One-cycle transfer request |
| sw_start | output | 1 | Pending software start bit |

## Verification
The bound checker watches several rules on every cycle:

- `adc_start` and `dma_req` are single-cycle pulses.
- Sampling always comes before `adc_start`.
- A request always comes with `eoc`.
- `dout` only moves with a result.
- The flag obeys its write-0 and write-1 rules.
- The start bit is already clear when sampling begins.

Only the directed scenarios can show counts and durations over time. These include exactly one conversion per single-mode trigger and the per-channel sample lengths. They also cover source selection, the pending start under disable, the drop of triggers while busy, and the stop after the in-flight conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int P_CH_W   = 5;
  localparam int P_SMP_W  = 3;
  localparam int P_RES_W  = 12;
  localparam int P_TRIG_N = 4;
  localparam int P_TSEL_W = $clog2(P_TRIG_N);
  localparam int P_REG_W  = P_CH_W + P_SMP_W;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CHAN = 2'd1;
  localparam logic [1:0] A_SMPT = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int B_EN   = 0;
  localparam int B_CONT = 1;
  localparam int B_XEN  = 2;
  localparam int B_XSEL = 3;
  localparam int B_DMA  = B_XSEL + P_TSEL_W;
  localparam int B_SWST = B_DMA + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONVERT} seq_state_t;
endpackage

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs #(
  parameter int CH_W   = adc_seq_pkg::P_CH_W,
  parameter int SMP_W  = adc_seq_pkg::P_SMP_W,
  parameter int TSEL_W = adc_seq_pkg::P_TSEL_W,
  parameter int REG_W  = adc_seq_pkg::P_REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              busy,
  input  logic              start_ack,
  input  logic              eoc_set,
  input  logic [CH_W-1:0]   rd_ch,
  output logic              en,
  output logic              cont,
  output logic              xen,
  output logic [TSEL_W-1:0] xsel,
  output logic              dma_en,
  output logic              sw_start,
  output logic              eoc,
  output logic [CH_W-1:0]   chan,
  output logic [SMP_W-1:0]  smp_code
);
  import adc_seq_pkg::*;
  localparam int N_CH = 1 << CH_W;

  logic [SMP_W-1:0] smp_tab [N_CH];
  logic wr_ctrl, wr_chan, wr_smpt, wr_stat;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_chan = wr_en && (wr_addr == A_CHAN);
  assign wr_smpt = wr_en && (wr_addr == A_SMPT);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; cont <= 1'b0; xen <= 1'b0; xsel <= '0;
      dma_en <= 1'b0; sw_start <= 1'b0; eoc <= 1'b0; chan <= '0;
    end else begin
      if (wr_ctrl) begin
        en     <= wr_data[B_EN];
        cont   <= wr_data[B_CONT];
        xen    <= wr_data[B_XEN];
        xsel   <= wr_data[B_XSEL +: TSEL_W];
        dma_en <= wr_data[B_DMA];
      end
      if (start_ack)
        sw_start <= 1'b0;
      else if (wr_ctrl && wr_data[B_SWST] && !busy)
        sw_start <= 1'b1;
      if (wr_chan)
        chan <= wr_data[CH_W-1:0];
      if (eoc_set)
        eoc <= 1'b1;
      else if (wr_stat && !wr_data[0])
        eoc <= 1'b0;
    end
  end

  // small table, no reset, written like a distributed RAM
  always_ff @(posedge clk) begin
    if (wr_smpt)
      smp_tab[wr_data[CH_W-1:0]] <= wr_data[CH_W +: SMP_W];
  end

  assign smp_code = smp_tab[rd_ch];
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int TRIG_N = adc_seq_pkg::P_TRIG_N,
  parameter int TSEL_W = adc_seq_pkg::P_TSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIG_N-1:0] ext_trig,
  input  logic              xen,
  input  logic [TSEL_W-1:0] xsel,
  output logic              xpulse
);
  logic [TRIG_N-1:0] prev;
  logic [TRIG_N-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= ext_trig;
  end

  assign rise   = ext_trig & ~prev;
  assign xpulse = xen && rise[xsel];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CH_W  = adc_seq_pkg::P_CH_W,
  parameter int SMP_W = adc_seq_pkg::P_SMP_W,
  parameter int RES_W = adc_seq_pkg::P_RES_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cont,
  input  logic             go,
  input  logic             dma_en,
  input  logic [CH_W-1:0]  chan_cfg,
  input  logic [SMP_W-1:0] smp_code,
  input  logic             adc_done,
  input  logic [RES_W-1:0] adc_data,
  output logic             busy,
  output logic             start_ack,
  output logic             conv_end,
  output logic             adc_sample,
  output logic             adc_start,
  output logic [CH_W-1:0]  adc_chan,
  output logic [RES_W-1:0] result,
  output logic             dma_req
);
  import adc_seq_pkg::*;
  localparam int CNT_W = SMP_W + 2;

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load;

  assign load       = {1'b0, smp_code, 1'b1};   // 2*code+1, phase = load+1 cycles
  assign busy       = (state != ST_IDLE);
  assign start_ack  = (state == ST_IDLE) && en && go;
  assign conv_end   = (state == ST_CONVERT) && adc_done;
  assign adc_sample = (state == ST_SAMPLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      adc_start <= 1'b0;
      adc_chan  <= '0;
      result    <= '0;
      dma_req   <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      dma_req   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_ack) begin
            state    <= ST_SAMPLE;
            cnt      <= load;
            adc_chan <= chan_cfg;
          end
        end
        ST_SAMPLE: begin
          if (cnt == '0) begin
            state     <= ST_CONVERT;
            adc_start <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONVERT: begin
          if (adc_done) begin
            result  <= adc_data;
            dma_req <= dma_en;
            if (en && cont) begin
              state    <= ST_SAMPLE;
              cnt      <= load;
              adc_chan <= chan_cfg;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W   = adc_seq_pkg::P_CH_W,
  parameter int SMP_W  = adc_seq_pkg::P_SMP_W,
  parameter int RES_W  = adc_seq_pkg::P_RES_W,
  parameter int TRIG_N = adc_seq_pkg::P_TRIG_N,
  parameter int TSEL_W = adc_seq_pkg::P_TSEL_W,
  parameter int REG_W  = adc_seq_pkg::P_REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [TRIG_N-1:0] ext_trig,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_data,
  output logic              adc_sample,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_chan,
  output logic [RES_W-1:0]  dout,
  output logic              eoc,
  output logic              dma_req,
  output logic              sw_start
);
  logic              en, cont, xen, dma_en;
  logic [TSEL_W-1:0] xsel;
  logic [CH_W-1:0]   chan;
  logic [SMP_W-1:0]  smp_code;
  logic              busy, start_ack, conv_end, xpulse;

  adc_cfg_regs #(.CH_W(CH_W), .SMP_W(SMP_W), .TSEL_W(TSEL_W), .REG_W(REG_W)) i_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .start_ack(start_ack), .eoc_set(conv_end), .rd_ch(chan),
    .en(en), .cont(cont), .xen(xen), .xsel(xsel), .dma_en(dma_en),
    .sw_start(sw_start), .eoc(eoc), .chan(chan), .smp_code(smp_code)
  );

  adc_trig_sel #(.TRIG_N(TRIG_N), .TSEL_W(TSEL_W)) i_trig (
    .clk(clk), .rst(rst), .ext_trig(ext_trig), .xen(xen), .xsel(xsel), .xpulse(xpulse)
  );

  adc_conv_seq #(.CH_W(CH_W), .SMP_W(SMP_W), .RES_W(RES_W)) i_seq (
    .clk(clk), .rst(rst), .en(en), .cont(cont), .go(sw_start || xpulse),
    .dma_en(dma_en), .chan_cfg(chan), .smp_code(smp_code),
    .adc_done(adc_done), .adc_data(adc_data),
    .busy(busy), .start_ack(start_ack), .conv_end(conv_end),
    .adc_sample(adc_sample), .adc_start(adc_start), .adc_chan(adc_chan),
    .result(dout), .dma_req(dma_req)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int RES_W = adc_seq_pkg::P_RES_W
) (
  input logic             clk,
  input logic             rst,
  input logic             stat_wr,
  input logic             stat_bit0,
  input logic             adc_done,
  input logic             adc_sample,
  input logic             adc_start,
  input logic [RES_W-1:0] dout,
  input logic             eoc,
  input logic             dma_req,
  input logic             sw_start
);
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);
  assert_sample_before_start_R6: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $past(adc_sample));
  assert_phase_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(adc_sample && adc_start));
  assert_dout_with_eoc_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> eoc);
  assert_eoc_set_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_bit0 && eoc) |=> eoc);
  assert_eoc_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !stat_bit0 && !adc_done) |=> !eoc);
  assert_dma_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    dma_req |=> !dma_req);
  assert_dma_with_eoc_R9: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> eoc);
  assert_start_selfclear_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_sample) |-> !sw_start);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_W(RES_W)) i_chk (
  .clk(clk), .rst(rst),
  .stat_wr(wr_en && (wr_addr == adc_seq_pkg::A_STAT)),
  .stat_bit0(wr_data[0]),
  .adc_done(adc_done), .adc_sample(adc_sample), .adc_start(adc_start),
  .dout(dout), .eoc(eoc), .dma_req(dma_req), .sw_start(sw_start)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int CONV = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [3:0]  ext_trig = 4'd0;
  logic        adc_done;
  logic [11:0] adc_data;
  logic        adc_sample, adc_start, eoc, dma_req, sw_start;
  logic [4:0]  adc_chan;
  logic [11:0] dout;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_dma = 0, dma_long = 0, smp_run = 0, smp_len = 0;
  int stub_cnt = 0, stub_seq = 0;
  logic dma_prev = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_trig(ext_trig), .adc_done(adc_done), .adc_data(adc_data),
    .adc_sample(adc_sample), .adc_start(adc_start), .adc_chan(adc_chan),
    .dout(dout), .eoc(eoc), .dma_req(dma_req), .sw_start(sw_start)
  );

  // converter stub: fixed latency after adc_start
  always @(posedge clk) begin
    if (rst) begin
      adc_done <= 1'b0; adc_data <= '0; stub_cnt <= 0; stub_seq <= 0;
    end else begin
      adc_done <= 1'b0;
      if (stub_cnt != 0) begin
        stub_cnt <= stub_cnt - 1;
        if (stub_cnt == 1) begin
          adc_done <= 1'b1;
          adc_data <= {adc_chan, 7'(stub_seq)};
          stub_seq <= stub_seq + 1;
        end
      end else if (adc_start) begin
        stub_cnt <= CONV;
      end
    end
  end

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (adc_start) n_start++;
      if (dma_req) n_dma++;
      if (dma_req && dma_prev) dma_long++;
      dma_prev = dma_req;
      if (adc_sample) smp_run++;
      else if (smp_run != 0) begin smp_len = smp_run; smp_run = 0; end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int b);
    @(negedge clk); ext_trig[b] = 1'b1;
    @(negedge clk); ext_trig[b] = 1'b0;
  endtask

  task automatic clr_counts();
    n_start = 0; n_dma = 0; dma_long = 0;
  endtask

  task automatic t_reset();
    check("R7 reset eoc", int'(eoc), 0);
    check("R7 reset dout", int'(dout), 0);
    check("R7 reset dma_req", int'(dma_req), 0);
    check("R7 reset sw_start", int'(sw_start), 0);
    check("R7 reset adc_sample", int'(adc_sample), 0);
  endtask

  task automatic t_single();
    wr(2'd2, 8'h25);            // ch5 code1
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h01);
    clr_counts();
    wr(2'd0, 8'h41);
    idle(2);
    check("R10 start self-clear", int'(sw_start), 0);
    idle(60);
    check("R1 single one conversion", n_start, 1);
    check("R1 idle afterwards", int'(adc_sample), 0);
    check("R7 eoc set", int'(eoc), 1);
    check("R3 channel in result", int'(dout[11:7]), 5);
    check("R6 sample length code1", smp_len, 4);
  endtask

  task automatic t_eoc_clear();
    wr(2'd3, 8'h01);
    check("R8 write 1 no effect", int'(eoc), 1);
    wr(2'd3, 8'h00);
    check("R8 write 0 clears", int'(eoc), 0);
  endtask

  task automatic t_smp_per_chan();
    wr(2'd2, 8'hA3);            // ch3 code5
    wr(2'd1, 8'd3);
    clr_counts();
    wr(2'd0, 8'h41);
    idle(4);
    check("R3 adc_chan during conversion", int'(adc_chan), 3);
    idle(60);
    check("R6 sample length code5", smp_len, 12);
    check("R3 channel 3 in result", int'(dout[11:7]), 3);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_enable();
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h00);
    clr_counts();
    wr(2'd0, 8'h40);
    idle(40);
    check("R4 no conversion while disabled", n_start, 0);
    check("R4 start stays pending", int'(sw_start), 1);
    wr(2'd0, 8'h01);
    idle(40);
    check("R4 pending start runs on enable", n_start, 1);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_ext();
    wr(2'd0, 8'h15);            // en, ext enable, source 2
    clr_counts();
    pulse(1);
    idle(40);
    check("R5 unselected source ignored", n_start, 0);
    pulse(2);
    idle(40);
    check("R5 selected source starts", n_start, 1);
    wr(2'd0, 8'h11);            // ext enable off
    clr_counts();
    pulse(2);
    idle(40);
    check("R5 ext disabled ignored", n_start, 0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_busy_ignore();
    wr(2'd0, 8'h15);
    clr_counts();
    pulse(2);
    idle(2);
    pulse(2);
    wr(2'd0, 8'h55);
    idle(60);
    check("R12 triggers while busy ignored", n_start, 1);
    check("R12 busy start write dropped", int'(sw_start), 0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_cont_dma();
    int s;
    wr(2'd0, 8'h23);
    clr_counts();
    wr(2'd0, 8'h63);
    idle(100);
    check("R2 repeats without triggers", int'(n_start >= 5), 1);
    wr(2'd0, 8'h21);            // continuous off
    idle(40);
    s = n_start;
    idle(60);
    check("R11 stop after continuous clear", n_start, s);
    check("R9 one request per result", n_dma, n_start);
    check("R9 request one cycle wide", dma_long, 0);
    wr(2'd0, 8'h63);
    idle(30);
    wr(2'd0, 8'h00);            // enable off
    idle(40);
    s = n_start;
    idle(60);
    check("R11 stop after enable clear", n_start, s);
    check("R11 idle after stop", int'(adc_sample), 0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_no_dma();
    wr(2'd0, 8'h01);
    clr_counts();
    wr(2'd0, 8'h41);
    idle(60);
    check("R9 conversion ran", n_start, 1);
    check("R9 no request without DMA", n_dma, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    idle(1);
    t_reset();
    t_single();
    t_eoc_clear();
    t_smp_per_chan();
    t_enable();
    t_ext();
    t_busy_ignore();
    t_cont_dma();
    t_no_dma();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule